// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as a chain of BCD counters. A single-cycle enable pulse arriving at 100 Hz advances the hundredths field; each field that wraps carries into the next one. The chain runs from seconds through minutes, hours, date and month to a two-digit year. A three-bit day-of-week value advances with every date change. Every field sits in a register and is presented directly as a BCD output, so a host can sample the time with no conversion.

Hours run in one of two formats, chosen by a mode bit. In 24-hour format the hour counts 00 to 23. In 12-hour format it counts 01 to 12, and a PM flag marks the afternoon. Month lengths are built in. February has 29 days whenever the two-digit year is a multiple of four, with no exception for century years.

A host preset port writes every field in one clock cycle and clears the hundredths. The preset takes precedence over a tick that arrives in the same cycle.

Top module: `bcd_calendar`

## Requirements
- R1: On each cycle with `tick`=1 and `load`=0, `hund` advances by one in BCD from 8'h00 to 8'h99 and wraps from 8'h99 to 8'h00.
- R2: `sec` and `min` count 8'h00 to 8'h59 in BCD. `sec` advances when `hund` wraps, and `min` advances when `sec` wraps, each returning to 8'h00 after 8'h59.
- R3: With `mode24`=1, `hour` counts 8'h00 to 8'h23. The step from 8'h23 to 8'h00 advances the date, and `pm` keeps its value.
- R4: With `mode24`=0, `hour` counts 8'h01 to 8'h12. The step 8'h11→8'h12 inverts `pm` (1 means PM), and 8'h12→8'h01 leaves `pm` unchanged. The step from 8'h11 with `pm`=1 to 8'h12 with `pm`=0 also advances the date.
- R5: `date` counts from 8'h01 up to the length of the month, then returns to 8'h01 and advances `month`. The length is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R6: In month 8'h02 the last day is 8'h29 when the value of the BCD `year` is a multiple of 4 (including 00) and 8'h28 otherwise.
- R7: `month` wraps from 8'h12 to 8'h01 and then advances `year`. `year` counts 8'h00 to 8'h99 and wraps to 8'h00.
- R8: `dow` advances by one at every date advance and wraps from 6 to 0.
- R9: After synchronous reset the outputs read 12 AM on 01/01 of year 00: `hund`, `sec` and `min` are 8'h00, `hour` is 8'h12, `pm` is 0, `mode24` is 0, `date` and `month` are 8'h01, `year` is 8'h00 and `dow` is 0.
- R10: With `load`=1, every field takes its `ld_*` value on the next clock edge and `hund` becomes 8'h00. This happens even when `tick` is also 1.
- R11: With `tick`=0 and `load`=0, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| load | input | 1 | Preset strobe for all fields |
| ld_sec | input | 8 | Preset seconds, BCD |
| ld_min | input | 8 | Preset minutes, BCD |
| ld_hour | input | 8 | Preset hour, BCD in the chosen format |
| ld_pm | input | 1 | Preset PM flag |
| ld_mode24 | input | 1 | Preset hour format, 1 = 24-hour |
| ld_date | input | 8 | Preset day of month, BCD |
| ld_month | input | 8 | Preset month, BCD |
| ld_year | input | 8 | Preset year, BCD |
| ld_dow | input | 3 | Preset day of week, 0 to 6 |
| hund | output | 8 | Hundredths of a second, BCD |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hour, BCD |
| pm | output | 1 | PM flag |
| mode24 | output | 1 | Hour format, 1 = 24-hour |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year, BCD |
| dow | output | 3 | Day of week |

## Verification
A host preset and a tick can fall in the same cycle, and that tick might otherwise ripple a carry through several fields. The bench drives `load` and `tick` together, both at an ordinary time and at 23:59:59.99. It then checks that every field holds only the preset values and that `hund` is 00, not 01. The other collision is a carry rippling from hundredths all the way to year in one tick. This is provoked by presetting the last hundredth-second of 31 December 99 and of the last days of February in leap and common years. A behavioural reference model judges every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd_t;

  localparam bcd_t HUND_MAX  = 8'h99;
  localparam bcd_t SEXA_MAX  = 8'h59;
  localparam bcd_t MONTH_MAX = 8'h12;
  localparam bcd_t YEAR_MAX  = 8'h99;
  localparam bcd_t HOUR_RST  = 8'h12;

  // Add one to a two-digit BCD value (no range wrap).
  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // A year is a leap year when its BCD value is a multiple of four.
  function automatic logic is_leap(bcd_t yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic bcd_t month_days(bcd_t mo, logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import cal_pkg::*;
#(
  parameter bcd_t LO  = 8'h00,
  parameter bcd_t HI  = 8'h59,
  parameter bcd_t RST = 8'h00
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  bcd_t load_val,
  input  logic inc,
  output bcd_t val,
  output logic carry
);
  assign carry = inc && (val == HI);

  always_ff @(posedge clk) begin
    if (rst)          val <= RST;
    else if (load_en) val <= load_val;
    else if (inc)     val <= carry ? LO : bcd_inc(val);
  end
endmodule

// File: rtl/hour_counter.sv
module hour_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  bcd_t ld_hour,
  input  logic ld_pm,
  input  logic ld_mode24,
  input  logic inc,
  output bcd_t hour,
  output logic pm,
  output logic mode24,
  output logic day_carry
);
  assign day_carry = inc && (mode24 ? (hour == 8'h23) : (hour == 8'h11 && pm));

  always_ff @(posedge clk) begin
    if (rst) begin
      hour   <= HOUR_RST;
      pm     <= 1'b0;
      mode24 <= 1'b0;
    end else if (load_en) begin
      hour   <= ld_hour;
      pm     <= ld_pm;
      mode24 <= ld_mode24;
    end else if (inc) begin
      if (mode24) begin
        hour <= (hour == 8'h23) ? 8'h00 : bcd_inc(hour);
      end else if (hour == 8'h12) begin
        hour <= 8'h01;
      end else if (hour == 8'h11) begin
        hour <= 8'h12;
        pm   <= ~pm;
      end else begin
        hour <= bcd_inc(hour);
      end
    end
  end
endmodule

// File: rtl/date_counter.sv
module date_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  bcd_t ld_date,
  input  bcd_t month,
  input  bcd_t year,
  input  logic inc,
  output bcd_t date,
  output logic carry
);
  bcd_t last_day;

  assign last_day = month_days(month, is_leap(year));
  assign carry    = inc && (date >= last_day);

  always_ff @(posedge clk) begin
    if (rst)          date <= 8'h01;
    else if (load_en) date <= ld_date;
    else if (inc)     date <= carry ? 8'h01 : bcd_inc(date);
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DOW_W    = 3,
  parameter int DOW_DAYS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [7:0]       ld_sec,
  input  logic [7:0]       ld_min,
  input  logic [7:0]       ld_hour,
  input  logic             ld_pm,
  input  logic             ld_mode24,
  input  logic [7:0]       ld_date,
  input  logic [7:0]       ld_month,
  input  logic [7:0]       ld_year,
  input  logic [DOW_W-1:0] ld_dow,
  output logic [7:0]       hund,
  output logic [7:0]       sec,
  output logic [7:0]       min,
  output logic [7:0]       hour,
  output logic             pm,
  output logic             mode24,
  output logic [7:0]       date,
  output logic [7:0]       month,
  output logic [7:0]       year,
  output logic [DOW_W-1:0] dow
);
  localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DOW_DAYS - 1);
  localparam int SEXA_N = 2;

  logic run;
  logic hund_c, hour_c, date_c, month_c, year_c;
  logic day_c;
  bcd_t sexa_ld  [SEXA_N];
  bcd_t sexa_val [SEXA_N];
  logic sexa_inc [SEXA_N+1];

  assign run = tick && !load;

  bcd_wrap_counter #(.LO(8'h00), .HI(HUND_MAX), .RST(8'h00)) u_hund (
    .clk(clk), .rst(rst), .load_en(load), .load_val(8'h00),
    .inc(run), .val(hund), .carry(hund_c)
  );

  assign sexa_ld[0]  = ld_sec;
  assign sexa_ld[1]  = ld_min;
  assign sexa_inc[0] = hund_c;

  // Seconds then minutes: identical 00..59 stages in a carry chain.
  for (genvar i = 0; i < SEXA_N; i++) begin : g_sexa
    bcd_wrap_counter #(.LO(8'h00), .HI(SEXA_MAX), .RST(8'h00)) u_stage (
      .clk(clk), .rst(rst), .load_en(load), .load_val(sexa_ld[i]),
      .inc(sexa_inc[i]), .val(sexa_val[i]), .carry(sexa_inc[i+1])
    );
  end

  assign sec = sexa_val[0];
  assign min = sexa_val[1];

  hour_counter u_hour (
    .clk(clk), .rst(rst), .load_en(load), .ld_hour(ld_hour),
    .ld_pm(ld_pm), .ld_mode24(ld_mode24), .inc(sexa_inc[SEXA_N]),
    .hour(hour), .pm(pm), .mode24(mode24), .day_carry(hour_c)
  );

  assign day_c = hour_c;

  date_counter u_date (
    .clk(clk), .rst(rst), .load_en(load), .ld_date(ld_date),
    .month(month), .year(year), .inc(day_c), .date(date), .carry(date_c)
  );

  bcd_wrap_counter #(.LO(8'h01), .HI(MONTH_MAX), .RST(8'h01)) u_month (
    .clk(clk), .rst(rst), .load_en(load), .load_val(ld_month),
    .inc(date_c), .val(month), .carry(month_c)
  );

  bcd_wrap_counter #(.LO(8'h00), .HI(YEAR_MAX), .RST(8'h00)) u_year (
    .clk(clk), .rst(rst), .load_en(load), .load_val(ld_year),
    .inc(month_c), .val(year), .carry(year_c)
  );

  always_ff @(posedge clk) begin
    if (rst)        dow <= '0;
    else if (load)  dow <= ld_dow;
    else if (day_c) dow <= (dow == DOW_LAST) ? '0 : dow + 1'b1;
  end

  // The year carry has no consumer; the two-digit year simply wraps.
  logic unused_ok;
  assign unused_ok = year_c;
endmodule

// File: rtl/cal_chk.sv
module cal_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic       pm,
  input logic       mode24,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [2:0] dow
);
  // R1
  hund_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && hund == 8'h99) |=> hund == 8'h00);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && hund == 8'h99 && sec == 8'h59) |=> sec == 8'h00);

  // R3
  hour24_range_chk: assert property (@(posedge clk) disable iff (rst)
    mode24 |-> hour <= 8'h23);

  // R4
  hour12_range_chk: assert property (@(posedge clk) disable iff (rst)
    !mode24 |-> (hour >= 8'h01 && hour <= 8'h12));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !mode24 && hund == 8'h99 && sec == 8'h59 &&
     min == 8'h59 && hour == 8'h11) |=> pm != $past(pm));

  // R5
  date_range_chk: assert property (@(posedge clk) disable iff (rst)
    (date >= 8'h01 && date <= 8'h31 && month >= 8'h01 && month <= 8'h12));

  // R8
  dow_range_chk: assert property (@(posedge clk) disable iff (rst)
    dow <= 3'd6);

  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (hund == 8'h00 && sec == $past(ld_sec) && min == $past(ld_min)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(hund) && $stable(sec) && $stable(min) &&
      $stable(hour) && $stable(pm) && $stable(date) && $stable(month) &&
      $stable(year) && $stable(dow)));
endmodule

bind bcd_calendar cal_chk u_cal_chk (
  .clk(clk), .rst(rst), .tick(tick), .load(load), .ld_sec(ld_sec),
  .ld_min(ld_min), .hund(hund), .sec(sec), .min(min), .hour(hour),
  .pm(pm), .mode24(mode24), .date(date), .month(month), .year(year),
  .dow(dow)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tick, load;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year;
  logic ld_pm, ld_mode24;
  logic [2:0] ld_dow;
  logic [7:0] hund, sec, min, hour, date, month, year;
  logic pm, mode24;
  logic [2:0] dow;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_pm(ld_pm),
    .ld_mode24(ld_mode24), .ld_date(ld_date), .ld_month(ld_month),
    .ld_year(ld_year), .ld_dow(ld_dow),
    .hund(hund), .sec(sec), .min(min), .hour(hour), .pm(pm),
    .mode24(mode24), .date(date), .month(month), .year(year), .dow(dow)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R9";

  // Reference state, plain integers.
  int m_hs, m_s, m_mi, m_hr, m_pm, m_m24, m_d, m_mo, m_y, m_dw;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_day();
    m_dw = (m_dw + 1) % 7;
    m_d++;
    if (m_d > days_in(m_mo, m_y)) begin
      m_d = 1;
      m_mo++;
      if (m_mo > 12) begin
        m_mo = 1;
        m_y = (m_y + 1) % 100;
      end
    end
  endtask

  task automatic model_hour();
    if (m_m24 != 0) begin
      m_hr++;
      if (m_hr == 24) begin m_hr = 0; model_day(); end
    end else if (m_hr == 11) begin
      m_hr = 12;
      m_pm = 1 - m_pm;
      if (m_pm == 0) model_day();
    end else if (m_hr == 12) begin
      m_hr = 1;
    end else begin
      m_hr++;
    end
  endtask

  task automatic model_tick();
    m_hs++;
    if (m_hs == 100) begin
      m_hs = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin m_mi = 0; model_hour(); end
      end
    end
  endtask

  task automatic check_all();
    logic [60:0] act, exp;
    act = {hund, sec, min, hour, pm, mode24, date, month, year, dow};
    exp = {to_bcd(m_hs), to_bcd(m_s), to_bcd(m_mi), to_bcd(m_hr), m_pm[0],
           m_m24[0], to_bcd(m_d), to_bcd(m_mo), to_bcd(m_y), 3'(m_dw)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (hund,sec,min,hour,pm,m24,date,month,year,dow)",
               cur_req, act, exp);
    end
  endtask

  task automatic cycle(input bit t);
    tick = t;
    load = 1'b0;
    if (t) model_tick();
    @(negedge clk);
    check_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1);
  endtask

  task automatic idle(input int n);
    string keep;
    keep = cur_req;
    cur_req = "R11";
    for (int i = 0; i < n; i++) cycle(1'b0);
    cur_req = keep;
  endtask

  // Preset hh:mm:ss, pm, 24h flag, date, month, year, dow; t = tick in same cycle.
  task automatic preset(input int hr, input int mi, input int s, input int p,
                        input int m24, input int d, input int mo, input int y,
                        input int dw, input bit t);
    ld_hour = to_bcd(hr); ld_min = to_bcd(mi); ld_sec = to_bcd(s);
    ld_pm = p[0]; ld_mode24 = m24[0]; ld_date = to_bcd(d);
    ld_month = to_bcd(mo); ld_year = to_bcd(y); ld_dow = 3'(dw);
    load = 1'b1; tick = t;
    m_hs = 0; m_s = s; m_mi = mi; m_hr = hr; m_pm = p; m_m24 = m24;
    m_d = d; m_mo = mo; m_y = y; m_dw = dw;
    @(negedge clk);
    check_all();
    load = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; load = 1'b0;
    ld_sec = 0; ld_min = 0; ld_hour = 0; ld_pm = 0; ld_mode24 = 0;
    ld_date = 0; ld_month = 0; ld_year = 0; ld_dow = 0;
    m_hs = 0; m_s = 0; m_mi = 0; m_hr = 12; m_pm = 0; m_m24 = 0;
    m_d = 1; m_mo = 1; m_y = 0; m_dw = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R9";  check_all();
    idle(4);

    cur_req = "R1";  run(250);
    idle(3);
    cur_req = "R2";  preset(0, 58, 59, 0, 1, 5, 3, 12, 1, 1'b0); run(6150);

    cur_req = "R3";  preset(23, 59, 59, 1, 1, 15, 6, 10, 2, 1'b0); run(105);
    idle(2);
    cur_req = "R4";  preset(11, 59, 59, 0, 0, 9, 7, 33, 3, 1'b0); run(105);
    cur_req = "R4";  preset(12, 59, 59, 1, 0, 9, 7, 33, 3, 1'b0); run(105);
    cur_req = "R4";  preset(11, 59, 59, 1, 0, 10, 7, 33, 3, 1'b0); run(105);

    cur_req = "R5";  preset(23, 59, 59, 0, 1, 30, 4, 21, 4, 1'b0); run(105);
    cur_req = "R5";  preset(11, 59, 59, 1, 0, 31, 1, 21, 5, 1'b0); run(105);
    cur_req = "R5";  preset(23, 59, 59, 0, 1, 30, 9, 21, 0, 1'b0); run(105);

    cur_req = "R6";  preset(23, 59, 59, 0, 1, 28, 2, 23, 1, 1'b0); run(105);
    cur_req = "R6";  preset(23, 59, 59, 0, 1, 28, 2, 24, 1, 1'b0); run(105);
    cur_req = "R6";  preset(23, 59, 59, 0, 1, 29, 2, 24, 2, 1'b0); run(105);
    cur_req = "R6";  preset(11, 59, 59, 1, 0, 28, 2, 0, 3, 1'b0); run(105);

    cur_req = "R7";  preset(11, 59, 59, 1, 0, 31, 12, 99, 6, 1'b0); run(105);
    cur_req = "R7";  preset(23, 59, 59, 0, 1, 31, 12, 41, 4, 1'b0); run(105);
    cur_req = "R8";  preset(23, 59, 59, 0, 1, 17, 8, 50, 6, 1'b0); run(105);

    cur_req = "R10"; preset(7, 30, 15, 1, 0, 12, 11, 66, 3, 1'b1);
    idle(2);
    cur_req = "R10"; run(99);
    cur_req = "R10"; preset(23, 59, 59, 0, 1, 31, 12, 99, 6, 1'b1);
    idle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule